// File: doc/BRIEF.md
# Code-Bus Alias Remapper for a Cache Front End

This block sits between a core's instruction-side bus and an instruction cache. It looks at each address-phase request and checks whether the address falls inside one of up to four programmable alias windows in the code region. On a match it rewrites the address into the external-memory physical range. It then sends the request either to the cache lookup port or to a bypass master port. The choice depends on the request's lookup attribute and on a global cache-enable input. Every other transfer field leaves the block as it arrived.

Translation is applied on both paths and stays active while the cache is switched off. The block records which port accepted each request, so that in the following data phase the matching response (read data, ready, error) is forwarded to the core in the same cycle it arrives. An address that is already physical, or that lies outside the code region, goes through untouched.

Top module: `cfe_remap`

## Requirements
- R1: A descriptor matches when its enable bit is 1 and the address lies in [alias base, alias base + 2^k). Here k is the descriptor's size exponent, limited to at most 27.
- R2: A matched address is translated to 0x9000_0000 + ((physical offset + address − alias base) mod 2^27), so the result always lies in 0x9000_0000–0x97FF_FFFF.
- R3: Only addresses in 0x0000_0000–0x07FF_FFFF or 0x1000_0000–0x1FFF_FFFF can be translated. Any other address, including an address already in the physical range, goes out unchanged even if a descriptor window covers it.
- R4: When several enabled descriptors match, the one with the lowest index supplies the translation.
- R5: An eligible address that no enabled descriptor matches goes out unchanged.
- R6: A request is cacheable when its lookup attribute is 1 and cache_en is 1. A cacheable request raises only c_req; every other request raises only m_req.
- R7: Translation applies equally on the cache port and on the bypass port, and it does not depend on cache_en.
- R8: The write, size, burst and protection fields appear unchanged on whichever port carries the request.
- R9: c_req and m_req are raised only while up_ready is 1. up_ready is 1 when no data phase is pending, and otherwise follows the ready of the port that accepted the previous request.
- R10: In the cycle after a request is accepted, up_rdata, up_err and up_ready come from the port that accepted it, with no added cycle of latency.
- R11: After reset, no data phase is pending, up_ready is 1, and no request is raised while up_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Global cache enable |
| rg_en | input | NUM_REGIONS | Per-descriptor enable |
| rg_alias | input | 32*NUM_REGIONS | Alias base per descriptor |
| rg_size_log2 | input | 5*NUM_REGIONS | Window size exponent per descriptor |
| rg_phys | input | 27*NUM_REGIONS | Offset into the external range per descriptor |
| up_valid | input | 1 | Request present in address phase |
| up_addr | input | 32 | Request address |
| up_write | input | 1 | Write flag |
| up_size | input | 3 | Transfer size |
| up_burst | input | 3 | Burst type |
| up_prot | input | 4 | Protection attributes |
| up_lookup | input | 1 | Lookup attribute, 1 = cacheable |
| up_rdata | output | DATA_W | Read data to core |
| up_ready | output | 1 | Transfer ready to core |
| up_err | output | 1 | Error response to core |
| c_req | output | 1 | Cache port request |
| c_addr | output | 32 | Cache port address (translated) |
| c_write | output | 1 | Cache port write flag |
| c_size | output | 3 | Cache port size |
| c_burst | output | 3 | Cache port burst |
| c_prot | output | 4 | Cache port protection |
| c_rdata | input | DATA_W | Cache read data |
| c_ready | input | 1 | Cache ready |
| c_err | input | 1 | Cache error |
| m_req | output | 1 | Bypass port request |
| m_addr | output | 32 | Bypass port address (translated) |
| m_write | output | 1 | Bypass port write flag |
| m_size | output | 3 | Bypass port size |
| m_burst | output | 3 | Bypass port burst |
| m_prot | output | 4 | Bypass port protection |
| m_rdata | input | DATA_W | Bypass read data |
| m_ready | input | 1 | Bypass ready |
| m_err | input | 1 | Bypass error |

## Verification
Addresses are swept at each window's first, last and mid offsets and at one step outside each edge. All four combinations of lookup attribute and cache enable are applied to every address. Together these separate off-by-one bound errors from routing errors. Overlapping windows distinguish priority order from a plain OR of hits, and windows that run past the code region or sit on the physical range show whether eligibility is checked apart from the window test. Mixed-route traffic and a forced bypass stall show whether the registered data-phase selection follows the right port and holds new requests back.

// File: rtl/cfe_remap_pkg.sv
package cfe_remap_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned EXT_W    = 27;
    localparam int unsigned SZ_W     = 5;
    localparam int unsigned MAX_LOG2 = EXT_W;
    localparam logic [ADDR_W-1:0] EXT_BASE = 32'h9000_0000;

    typedef struct packed {
        logic       write;
        logic [2:0] size;
        logic [2:0] burst;
        logic [3:0] prot;
    } xfer_attr_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] alias_base;
        logic [SZ_W-1:0]   size_log2;
        logic [EXT_W-1:0]  phys_off;
    } region_t;

    typedef enum logic [1:0] {
        DP_IDLE   = 2'd0,
        DP_CACHE  = 2'd1,
        DP_BYPASS = 2'd2
    } dphase_e;

    // Code region: low 128 MiB or the 256 MiB block at 0x1000_0000.
    function automatic logic in_code_region(input logic [ADDR_W-1:0] a);
        return (a[31:27] == 5'b00000) || (a[31:28] == 4'b0001);
    endfunction

    function automatic logic [SZ_W-1:0] clamp_log2(input logic [SZ_W-1:0] lg);
        return (lg > SZ_W'(MAX_LOG2)) ? SZ_W'(MAX_LOG2) : lg;
    endfunction

    function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] base,
                                        input logic [SZ_W-1:0]   lg);
        logic [ADDR_W:0] lo;
        logic [ADDR_W:0] hi;
        lo = {1'b0, base};
        hi = lo + ((ADDR_W+1)'(1) << lg);
        return ({1'b0, a} >= lo) && ({1'b0, a} < hi);
    endfunction

    function automatic logic [ADDR_W-1:0] ext_translate(input logic [ADDR_W-1:0] a,
                                                        input logic [ADDR_W-1:0] base,
                                                        input logic [EXT_W-1:0]  phys);
        logic [EXT_W-1:0] sum;
        sum = phys + a[EXT_W-1:0] - base[EXT_W-1:0];
        return {EXT_BASE[ADDR_W-1:EXT_W], sum};
    endfunction

endpackage

// File: rtl/cfe_region_match.sv
module cfe_region_match
    import cfe_remap_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  region_t           regions [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] hit,
    output logic [ADDR_W-1:0] xlat [NUM_REGIONS]
);

    logic eligible;
    assign eligible = in_code_region(addr);

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
            logic [SZ_W-1:0] lg_eff;
            assign lg_eff  = clamp_log2(regions[g].size_log2);
            assign hit[g]  = eligible && regions[g].en &&
                             window_hit(addr, regions[g].alias_base, lg_eff);
            assign xlat[g] = ext_translate(addr, regions[g].alias_base,
                                           regions[g].phys_off);
        end
    endgenerate

endmodule

// File: rtl/cfe_prio_pick.sv
module cfe_prio_pick #(
    parameter int unsigned NUM = 4,
    parameter int unsigned W   = 32
) (
    input  logic [NUM-1:0] hit,
    input  logic [W-1:0]   cand [NUM],
    input  logic [W-1:0]   dflt,
    output logic [W-1:0]   sel,
    output logic           any
);

    always_comb begin
        sel = dflt;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit[i]) sel = cand[i];
        end
    end

    assign any = |hit;

endmodule

// File: rtl/cfe_dphase_route.sv
module cfe_dphase_route
    import cfe_remap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              to_cache,
    input  logic [DATA_W-1:0] c_rdata,
    input  logic              c_ready,
    input  logic              c_err,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic              m_ready,
    input  logic              m_err,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_ready,
    output logic              up_err
);

    dphase_e dp_q;

    always_comb begin
        unique case (dp_q)
            DP_CACHE: begin
                up_ready = c_ready;
                up_rdata = c_rdata;
                up_err   = c_err;
            end
            DP_BYPASS: begin
                up_ready = m_ready;
                up_rdata = m_rdata;
                up_err   = m_err;
            end
            default: begin
                up_ready = 1'b1;
                up_rdata = '0;
                up_err   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= DP_IDLE;
        end else if (up_ready) begin
            if (accept) dp_q <= to_cache ? DP_CACHE : DP_BYPASS;
            else        dp_q <= DP_IDLE;
        end
    end

endmodule

// File: rtl/cfe_remap.sv
module cfe_remap
    import cfe_remap_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned DATA_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cache_en,
    input  logic [NUM_REGIONS-1:0]        rg_en,
    input  logic [NUM_REGIONS*32-1:0]     rg_alias,
    input  logic [NUM_REGIONS*5-1:0]      rg_size_log2,
    input  logic [NUM_REGIONS*27-1:0]     rg_phys,
    input  logic                          up_valid,
    input  logic [31:0]                   up_addr,
    input  logic                          up_write,
    input  logic [2:0]                    up_size,
    input  logic [2:0]                    up_burst,
    input  logic [3:0]                    up_prot,
    input  logic                          up_lookup,
    output logic [DATA_W-1:0]             up_rdata,
    output logic                          up_ready,
    output logic                          up_err,
    output logic                          c_req,
    output logic [31:0]                   c_addr,
    output logic                          c_write,
    output logic [2:0]                    c_size,
    output logic [2:0]                    c_burst,
    output logic [3:0]                    c_prot,
    input  logic [DATA_W-1:0]             c_rdata,
    input  logic                          c_ready,
    input  logic                          c_err,
    output logic                          m_req,
    output logic [31:0]                   m_addr,
    output logic                          m_write,
    output logic [2:0]                    m_size,
    output logic [2:0]                    m_burst,
    output logic [3:0]                    m_prot,
    input  logic [DATA_W-1:0]             m_rdata,
    input  logic                          m_ready,
    input  logic                          m_err
);

    region_t           regions [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] hit;
    logic [ADDR_W-1:0] xlat [NUM_REGIONS];
    logic [ADDR_W-1:0] out_addr;
    logic              any_hit;
    xfer_attr_t        attr;
    logic              cacheable;
    logic              accept;

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_unpack
            assign regions[g].en         = rg_en[g];
            assign regions[g].alias_base = rg_alias[g*ADDR_W +: ADDR_W];
            assign regions[g].size_log2  = rg_size_log2[g*SZ_W +: SZ_W];
            assign regions[g].phys_off   = rg_phys[g*EXT_W +: EXT_W];
        end
    endgenerate

    cfe_region_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
        .addr    (up_addr),
        .regions (regions),
        .hit     (hit),
        .xlat    (xlat)
    );

    cfe_prio_pick #(.NUM(NUM_REGIONS), .W(ADDR_W)) u_pick (
        .hit  (hit),
        .cand (xlat),
        .dflt (up_addr),
        .sel  (out_addr),
        .any  (any_hit)
    );

    assign attr      = '{write: up_write, size: up_size, burst: up_burst, prot: up_prot};
    assign cacheable = up_lookup & cache_en;
    assign accept    = up_valid & up_ready;

    assign c_req   = accept & cacheable;
    assign m_req   = accept & ~cacheable;
    assign c_addr  = out_addr;
    assign m_addr  = out_addr;
    assign c_write = attr.write;
    assign c_size  = attr.size;
    assign c_burst = attr.burst;
    assign c_prot  = attr.prot;
    assign m_write = attr.write;
    assign m_size  = attr.size;
    assign m_burst = attr.burst;
    assign m_prot  = attr.prot;

    cfe_dphase_route #(.DATA_W(DATA_W)) u_route (
        .clk      (clk),
        .rst      (rst),
        .accept   (up_valid),
        .to_cache (cacheable),
        .c_rdata  (c_rdata),
        .c_ready  (c_ready),
        .c_err    (c_err),
        .m_rdata  (m_rdata),
        .m_ready  (m_ready),
        .m_err    (m_err),
        .up_rdata (up_rdata),
        .up_ready (up_ready),
        .up_err   (up_err)
    );

    logic unused_any;
    assign unused_any = any_hit;

endmodule

// File: rtl/cfe_remap_chk.sv
module cfe_remap_chk
    import cfe_remap_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cache_en,
    input logic              up_valid,
    input logic [31:0]       up_addr,
    input logic              up_write,
    input logic [2:0]        up_size,
    input logic [2:0]        up_burst,
    input logic [3:0]        up_prot,
    input logic [DATA_W-1:0] up_rdata,
    input logic              up_ready,
    input logic              up_err,
    input logic              c_req,
    input logic [31:0]       c_addr,
    input logic              m_req,
    input logic [31:0]       m_addr,
    input logic              m_write,
    input logic [2:0]        m_size,
    input logic [2:0]        m_burst,
    input logic [3:0]        m_prot,
    input logic [DATA_W-1:0] c_rdata,
    input logic              c_ready,
    input logic              c_err,
    input logic [DATA_W-1:0] m_rdata,
    input logic              m_ready,
    input logic              m_err
);

    a_r6_single_port: assert property (@(posedge clk) disable iff (rst)
        !(c_req && m_req));

    a_r6_cache_off: assert property (@(posedge clk) disable iff (rst)
        !cache_en |-> !c_req);

    a_r9_hold_when_busy: assert property (@(posedge clk) disable iff (rst)
        !up_ready |-> (!c_req && !m_req));

    a_r3_outside_cache: assert property (@(posedge clk) disable iff (rst)
        (c_req && !in_code_region(up_addr)) |-> (c_addr == up_addr));

    a_r3_outside_byp: assert property (@(posedge clk) disable iff (rst)
        (m_req && !in_code_region(up_addr)) |-> (m_addr == up_addr));

    a_r2_ext_range: assert property (@(posedge clk) disable iff (rst)
        (m_req && (m_addr != up_addr)) |-> (m_addr[31:27] == 5'b10010));

    a_r8_byp_fields: assert property (@(posedge clk) disable iff (rst)
        m_req |-> (m_write == up_write && m_size == up_size &&
                   m_burst == up_burst && m_prot == up_prot));

    a_r10_cache_resp: assert property (@(posedge clk) disable iff (rst)
        c_req |=> (up_rdata == c_rdata && up_ready == c_ready && up_err == c_err));

    a_r10_byp_resp: assert property (@(posedge clk) disable iff (rst)
        m_req |=> (up_rdata == m_rdata && up_ready == m_ready && up_err == m_err));

    a_r11_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> up_ready);

    a_r11_no_req_idle: assert property (@(posedge clk) disable iff (rst)
        !up_valid |-> (!c_req && !m_req));

endmodule

bind cfe_remap cfe_remap_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cache_en (cache_en),
    .up_valid (up_valid),
    .up_addr  (up_addr),
    .up_write (up_write),
    .up_size  (up_size),
    .up_burst (up_burst),
    .up_prot  (up_prot),
    .up_rdata (up_rdata),
    .up_ready (up_ready),
    .up_err   (up_err),
    .c_req    (c_req),
    .c_addr   (c_addr),
    .m_req    (m_req),
    .m_addr   (m_addr),
    .m_write  (m_write),
    .m_size   (m_size),
    .m_burst  (m_burst),
    .m_prot   (m_prot),
    .c_rdata  (c_rdata),
    .c_ready  (c_ready),
    .c_err    (c_err),
    .m_rdata  (m_rdata),
    .m_ready  (m_ready),
    .m_err    (m_err)
);

// File: tb/test_cfe_remap.sv
module test_cfe_remap;

    localparam int NR = 4;
    localparam int DW = 32;

    logic clk = 0;
    logic rst = 1;
    logic cache_en = 0;
    logic [NR-1:0]    rg_en = '0;
    logic [NR*32-1:0] rg_alias = '0;
    logic [NR*5-1:0]  rg_size_log2 = '0;
    logic [NR*27-1:0] rg_phys = '0;
    logic up_valid = 0;
    logic [31:0] up_addr = '0;
    logic up_write = 0;
    logic [2:0] up_size = '0, up_burst = '0;
    logic [3:0] up_prot = '0;
    logic up_lookup = 0;
    logic [DW-1:0] up_rdata;
    logic up_ready, up_err;
    logic c_req, c_write, m_req, m_write;
    logic [31:0] c_addr, m_addr;
    logic [2:0] c_size, c_burst, m_size, m_burst;
    logic [3:0] c_prot, m_prot;
    logic [DW-1:0] c_rdata = '0, m_rdata = '0;
    logic c_ready = 1, c_err = 0, m_ready = 1, m_err = 0;

    always #5 clk = ~clk;

    cfe_remap #(.NUM_REGIONS(NR), .DATA_W(DW)) i_cfe_remap (.*);

    int n_vec = 0;
    int n_bad = 0;
    int seq = 0;
    int prev_route = 0;  // 0 idle, 1 cache, 2 bypass

    logic        b_en   [NR];
    logic [31:0] b_alias[NR];
    logic [4:0]  b_lg   [NR];
    logic [26:0] b_phys [NR];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_cfg();
        for (int i = 0; i < NR; i++) begin
            rg_en[i] = b_en[i];
            rg_alias[i*32 +: 32] = b_alias[i];
            rg_size_log2[i*5 +: 5] = b_lg[i];
            rg_phys[i*27 +: 27] = b_phys[i];
        end
    endtask

    function automatic bit code_ok(input logic [31:0] a);
        return (a < 32'h0800_0000) || (a >= 32'h1000_0000 && a < 32'h2000_0000);
    endfunction

    // Expected address and requirement tag, computed from the requirement text.
    function automatic logic [31:0] model(input logic [31:0] a, output string tag);
        longint unsigned lo, span;
        int nhit = 0;
        logic [31:0] r = a;
        tag = "R5";
        if (!code_ok(a)) begin
            tag = "R3";
            return a;
        end
        for (int i = 0; i < NR; i++) begin
            lo = longint'(b_alias[i]);
            span = 64'd1 << ((b_lg[i] > 5'd27) ? 27 : b_lg[i]);
            if (b_en[i] && longint'(a) >= lo && longint'(a) < lo + span) begin
                if (nhit == 0)
                    r = 32'h9000_0000 + ((32'(b_phys[i]) + a - b_alias[i]) & 32'h07FF_FFFF);
                nhit++;
            end
        end
        if (nhit > 1) tag = "R4";
        else if (nhit == 1) tag = "R1 R2";
        return r;
    endfunction

    task automatic check_dphase();
        if (prev_route == 1)
            chk(up_rdata == c_rdata && up_err == c_err, "R10 cache data", up_rdata, c_rdata);
        else if (prev_route == 2)
            chk(up_rdata == m_rdata && up_err == m_err, "R10 bypass data", up_rdata, m_rdata);
        chk(up_ready == 1'b1, "R9 ready", 32'(up_ready), 32'd1);
    endtask

    task automatic do_vec(input logic [31:0] a, input logic lk, input logic ce);
        string tag;
        logic [31:0] exp;
        bit cached;
        @(posedge clk); #2;
        seq++;
        c_rdata = 32'hC000_0000 + 32'(seq);
        m_rdata = 32'hD000_0000 + 32'(seq);
        c_err = seq[1];
        m_err = seq[0];
        up_valid = 1; up_addr = a; up_lookup = lk; cache_en = ce;
        up_write = a[2]; up_size = a[5:3]; up_burst = a[8:6]; up_prot = a[12:9];
        #2;
        check_dphase();
        exp = model(a, tag);
        cached = lk & ce;
        chk(c_req == cached && m_req == !cached, "R6 route", {30'd0, c_req, m_req}, {30'd0, cached, !cached});
        if (cached) chk(c_addr == exp, tag, c_addr, exp);
        else        chk(m_addr == exp, (ce ? tag : "R7 cache off"), m_addr, exp);
        if (cached)
            chk(c_write == a[2] && c_size == a[5:3] && c_burst == a[8:6] && c_prot == a[12:9],
                "R8 cache fields", {21'd0, c_prot, c_burst, c_size, c_write}, {19'd0, a[12:0]} >> 2);
        else
            chk(m_write == a[2] && m_size == a[5:3] && m_burst == a[8:6] && m_prot == a[12:9],
                "R8 bypass fields", {21'd0, m_prot, m_burst, m_size, m_write}, {19'd0, a[12:0]} >> 2);
        prev_route = cached ? 1 : 2;
    endtask

    task automatic do_idle();
        @(posedge clk); #2;
        up_valid = 0;
        #2;
        check_dphase();
        chk(!c_req && !m_req, "R11 idle", {30'd0, c_req, m_req}, 32'd0);
        prev_route = 0;
    endtask

    task automatic sweep_edges();
        longint unsigned sz;
        longint offs [9];
        for (int i = 0; i < NR; i++) begin
            sz = 64'd1 << ((b_lg[i] > 5'd27) ? 27 : b_lg[i]);
            offs = '{-2, -1, 0, 1, longint'(sz/2), longint'(sz) - 2, longint'(sz) - 1, longint'(sz), longint'(sz) + 1};
            for (int k = 0; k < 9; k++) begin
                for (int m = 0; m < 4; m++) begin
                    do_vec(32'(longint'(b_alias[i]) + offs[k]), m[0], m[1]);
                end
            end
        end
    endtask

    task automatic sweep_lfsr(input int n);
        logic [31:0] r = 32'hACE1_2345;
        logic [31:0] a;
        for (int k = 0; k < n; k++) begin
            r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
            if (r[7]) a = r;
            else      a = b_alias[r[1:0]] + (r >> (12 + r[5:2]));
            do_vec(a, r[8], r[9]);
        end
    endtask

    initial begin
        string tg;
        logic [31:0] e;
        repeat (3) @(posedge clk);
        #2; rst = 0;
        #2;
        chk(up_ready == 1'b1, "R11 reset ready", 32'(up_ready), 32'd1);
        chk(!c_req && !m_req, "R11 reset no req", {30'd0, c_req, m_req}, 32'd0);

        // Config A: overlapping windows, wrap of the physical offset, window past code region.
        b_en    = '{1, 1, 1, 1};
        b_alias = '{32'h0001_0000, 32'h0001_8000, 32'h1000_0000, 32'h07FF_0000};
        b_lg    = '{5'd16, 5'd12, 5'd20, 5'd20};
        b_phys  = '{27'h000_0000, 27'h200_0000, 27'h7FF_F000, 27'h100_0000};
        load_cfg();
        sweep_edges();
        do_idle();
        sweep_lfsr(1500);

        // R4: disabling region 0 lets region 1 take over its overlap.
        b_en[0] = 0; load_cfg();
        do_vec(32'h0001_8010, 1, 1);
        e = model(32'h0001_8010, tg);
        chk(e == 32'h9200_0010, "R4 model sanity", e, 32'h9200_0010);

        // Config B: region on the physical range, oversized exponent clamped.
        b_en    = '{0, 1, 1, 1};
        b_lg    = '{5'd16, 5'd31, 5'd20, 5'd16};
        b_alias = '{32'h0001_0000, 32'h0001_8000, 32'h1000_0000, 32'h9000_0000};
        load_cfg();
        sweep_edges();
        do_idle();
        sweep_lfsr(800);

        // R9: bypass data phase stalls; a new cacheable request must wait.
        do_vec(32'h0001_8004, 0, 1);
        @(posedge clk); #2;
        m_ready = 0; up_valid = 1; up_addr = 32'h0001_8008; up_lookup = 1; cache_en = 1;
        #2;
        chk(up_ready == 1'b0, "R9 stall ready", 32'(up_ready), 32'd0);
        chk(!c_req && !m_req, "R9 stall no req", {30'd0, c_req, m_req}, 32'd0);
        @(posedge clk); #2;
        chk(up_ready == 1'b0, "R9 stall held", 32'(up_ready), 32'd0);
        m_ready = 1;
        #2;
        e = model(32'h0001_8008, tg);
        chk(up_ready == 1'b1 && c_req == 1'b1, "R9 release", {30'd0, up_ready, c_req}, 32'd3);
        chk(c_addr == e, "R9 held address", c_addr, e);
        prev_route = 1;
        do_vec(32'h1234_5678, 0, 0);
        do_idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule